// File: doc/BRIEF.md
# Watchdog Timer with Programmable Alert Output

A supervision counter that software must service periodically. A free-running millisecond strobe feeds a prescaler that derives second and minute events. The down-counter, loaded from an 8-bit range value, consumes one of these events per step. If the counter passes zero before software writes the range value again, a sticky status flag is set and an alert pin is asserted. Software clears the flag by writing it with a one.

The alert can be a level that persists until it is cleared, or a single timed pulse with one of four widths. It can be active low, which is the default and suits a wired-OR reset or interrupt line, or active high. The pin comes out as a data value plus a drive enable, so an open-drain pad can release the line whenever the alert is inactive.

Register access is reduced to three write strobes that share one data bus: control, range and status. Reads are left to the surrounding register file.

Top module: `wdt_alert`

## Requirements
- R1: After reset the status flag is 0, `alert_oe_o` is 0 and `alert_o` is 1, because the default polarity is active low and the alert is inactive.
- R2: Control bit 0 enables the timer. While it is 0, no timeout occurs and the prescaler is held at zero, however many ticks arrive.
- R3: A second is TICKS_PER_SEC strobes of `tick_ms_i`, counted from the cycle in which the timer is enabled or kicked. With a range of N, the timeout is raised on the (N+1)th unit event. A range of 0 therefore times out on the first unit event.
- R4: Control bit 1 set selects minutes as the unit, where one minute is SEC_PER_MIN seconds. When the bit is clear, the unit is seconds.
- R5: A write to the range register reloads the counter and restarts the prescaler. This write is the kick. A kick in the same cycle as an expiring unit event suppresses that timeout.
- R6: A timeout sets the status flag, and the flag holds its value. A status write with data bit 0 = 1 clears it. A status write with bit 0 = 0 has no effect. A timeout in the same cycle as a clear leaves the flag set.
- R7: In level mode (control bit 2 = 0), the alert is asserted from the cycle after the timeout. It stays asserted until the status flag is cleared or the timer is disabled.
- R8: In pulse mode (control bit 2 = 1), a timeout produces one pulse lasting PWx tick strobes. The width code in control bits 5:4 selects the width: 00 gives PW0 (default 1 ms), 01 gives PW1 (20 ms), 10 gives PW2 (100 ms) and 11 gives PW3 (4 s). No further timeout occurs until the next kick.
- R9: Control bit 3 sets the polarity. When it is 0, an asserted alert drives `alert_o` low. When it is 1, an asserted alert drives `alert_o` high. `alert_oe_o` is 1 exactly while the alert is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle strobe at the timebase rate (1 kHz) |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| range_wr_i | input | 1 | Write strobe for the range register (kick) |
| stat_wr_i | input | 1 | Write strobe for the status register (write 1 to clear) |
| wdata_i | input | DATA_W | Shared write data |
| alert_o | output | 1 | Alert pin level |
| alert_oe_o | output | 1 | Alert pin drive enable |
| sts_o | output | 1 | Sticky timeout status |

## Verification
A behavioural model runs alongside the design and is compared on every cycle. The timer is exercised with a continuous tick and with a tick on every other cycle, which tells apart prescaler counting of strobes from counting of clock cycles.

Directed sequences cover the following cases:
- Range values of 0, 1, 2 and 3 in both units, which separate an off-by-one in the reload value from one in the unit length.
- Kicks placed both before the expiry edge and exactly on it.
- All four pulse widths, with both polarities.
- A status clear that lands on the timeout edge.

// File: rtl/wdt_alert_pkg.sv
package wdt_alert_pkg;

  // Control register layout, LSB first: enable, unit, mode, polarity, width
  typedef struct packed {
    logic [1:0] pw_sel;
    logic       act_high;
    logic       pulse_mode;
    logic       unit_min;
    logic       enable;
  } wdt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdt_ctrl_t);

endpackage

// File: rtl/wdt_alert_timebase.sv
module wdt_alert_timebase #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic sec_tick_o,
  output logic min_tick_o
);

  localparam int unsigned MS_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned SC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_SEC - 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SEC_PER_MIN - 1);

  logic [MS_W-1:0] ms_q, ms_d;
  logic [SC_W-1:0] sc_q, sc_d;

  always_comb begin
    sec_tick_o = run_i && !restart_i && tick_i && (ms_q == MS_LAST);
    min_tick_o = sec_tick_o && (sc_q == SC_LAST);
    ms_d = ms_q;
    sc_d = sc_q;
    if (!run_i || restart_i) begin
      ms_d = '0;
      sc_d = '0;
    end else if (tick_i) begin
      ms_d = (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
      if (sec_tick_o) begin
        sc_d = min_tick_o ? '0 : sc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q <= '0;
      sc_q <= '0;
    end else begin
      ms_q <= ms_d;
      sc_q <= sc_d;
    end
  end

  // R2: an idle prescaler is parked at zero one cycle later
  assert_idle_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (ms_q == '0 && sc_q == '0));

endmodule

// File: rtl/wdt_alert_downcount.sv
module wdt_alert_downcount #(
  parameter int unsigned RANGE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               unit_tick_i,
  input  logic               range_wr_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               stat_clr_i,
  output logic               timeout_o,
  output logic               sts_o
);

  logic [RANGE_W-1:0] range_q;
  logic [RANGE_W-1:0] cnt_q, cnt_d;
  logic               fired_q, fired_d;
  logic               sts_q, sts_d;

  always_comb begin
    timeout_o = en_i && unit_tick_i && !range_wr_i && !fired_q && (cnt_q == '0);
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (range_wr_i) begin
      cnt_d   = range_i;
      fired_d = 1'b0;
    end else if (!en_i) begin
      cnt_d   = range_q;
      fired_d = 1'b0;
    end else if (unit_tick_i && !fired_q) begin
      if (cnt_q == '0) fired_d = 1'b1;
      else             cnt_d   = cnt_q - 1'b1;
    end
    if (timeout_o)       sts_d = 1'b1;
    else if (stat_clr_i) sts_d = 1'b0;
    else                 sts_d = sts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= '0;
    end else if (range_wr_i) begin
      range_q <= range_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      sts_q   <= sts_d;
    end
  end

  assign sts_o = sts_q;

  assert_sts_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !stat_clr_i) |=> sts_q);

  assert_sts_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !timeout_o) |=> !sts_q);

  assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !range_wr_i) |=> !timeout_o);

endmodule

// File: rtl/wdt_alert_drive.sv
module wdt_alert_drive #(
  parameter int unsigned PW0 = 1,
  parameter int unsigned PW1 = 20,
  parameter int unsigned PW2 = 100,
  parameter int unsigned PW3 = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       pulse_mode_i,
  input  logic       act_high_i,
  input  logic [1:0] pw_sel_i,
  input  logic       tick_i,
  input  logic       timeout_i,
  input  logic       sts_i,
  output logic       alert_o,
  output logic       alert_oe_o
);

  localparam int unsigned PW_A   = (PW0 > PW1) ? PW0 : PW1;
  localparam int unsigned PW_B   = (PW2 > PW3) ? PW2 : PW3;
  localparam int unsigned PW_MAX = (PW_A > PW_B) ? PW_A : PW_B;
  localparam int unsigned PL_W   = $clog2(PW_MAX + 1);

  logic [PL_W-1:0] width_sel;
  logic [PL_W-1:0] pl_q, pl_d;
  logic            active;

  always_comb begin
    unique case (pw_sel_i)
      2'd0:    width_sel = PL_W'(PW0);
      2'd1:    width_sel = PL_W'(PW1);
      2'd2:    width_sel = PL_W'(PW2);
      default: width_sel = PL_W'(PW3);
    endcase
    pl_d = pl_q;
    if (!en_i)                          pl_d = '0;
    else if (timeout_i && pulse_mode_i) pl_d = width_sel;
    else if (tick_i && pl_q != '0)      pl_d = pl_q - 1'b1;
    active     = pulse_mode_i ? (pl_q != '0) : (sts_i && en_i);
    alert_oe_o = active;
    alert_o    = act_high_i ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pl_q <= '0;
    else        pl_q <= pl_d;
  end

  assert_pulse_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pl_q != '0 && !timeout_i) |=> (pl_q <= $past(pl_q)));

  assert_level_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode_i && !sts_i) |-> !alert_oe_o);

endmodule

// File: rtl/wdt_alert.sv
module wdt_alert
  import wdt_alert_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned RANGE_W       = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PW0           = 1,
  parameter int unsigned PW1           = 20,
  parameter int unsigned PW2           = 100,
  parameter int unsigned PW3           = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms_i,
  input  logic              ctrl_wr_i,
  input  logic              range_wr_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              alert_o,
  output logic              alert_oe_o,
  output logic              sts_o
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  wdt_ctrl_t  ctrl_q;
  logic       sec_tick, min_tick, unit_tick, timeout;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)    ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= wdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  wdt_alert_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SEC_PER_MIN  (SEC_PER_MIN)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .run_i     (ctrl_q.enable),
    .restart_i (range_wr_i),
    .tick_i    (tick_ms_i),
    .sec_tick_o(sec_tick),
    .min_tick_o(min_tick)
  );

  assign unit_tick = ctrl_q.unit_min ? min_tick : sec_tick;

  wdt_alert_downcount #(
    .RANGE_W(RANGE_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .en_i       (ctrl_q.enable),
    .unit_tick_i(unit_tick),
    .range_wr_i (range_wr_i),
    .range_i    (wdata_i[RANGE_W-1:0]),
    .stat_clr_i (stat_wr_i && wdata_i[0]),
    .timeout_o  (timeout),
    .sts_o      (sts_o)
  );

  wdt_alert_drive #(
    .PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)
  ) u_drive (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .en_i        (ctrl_q.enable),
    .pulse_mode_i(ctrl_q.pulse_mode),
    .act_high_i  (ctrl_q.act_high),
    .pw_sel_i    (ctrl_q.pw_sel),
    .tick_i      (tick_ms_i),
    .timeout_i   (timeout),
    .sts_i       (sts_o),
    .alert_o     (alert_o),
    .alert_oe_o  (alert_oe_o)
  );

  assert_no_timeout_idle_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ctrl_q.enable |-> !timeout);

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ctrl_q.enable |-> !alert_oe_o);

  assert_kick_wins_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (range_wr_i && !sts_o && !(stat_wr_i && wdata_i[0])) |=> !sts_o);

endmodule

// File: tb/wdt_alert_tb.sv
module wdt_alert_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam int P0 = 1, P1 = 3, P2 = 5, P3 = 9;
  localparam int LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       cwr = 1'b0, rwr = 1'b0, swr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       alert, oe, sts;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_alert #(
    .TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .RANGE_W(8), .DATA_W(8),
    .PW0(P0), .PW1(P1), .PW2(P2), .PW3(P3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms_i(tick),
    .ctrl_wr_i(cwr), .range_wr_i(rwr), .stat_wr_i(swr), .wdata_i(wd),
    .alert_o(alert), .alert_oe_o(oe), .sts_o(sts)
  );

  int    vectors = 0, fails = 0, cyc = 0, tick_mode = 0, total = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  bit m_en, m_umin, m_pulse, m_hi, m_fired, m_sts;
  int m_pw, m_range, m_cnt, m_ms, m_sec, m_pl;

  function automatic int width_of(int s);
    case (s)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit st, mt, ut, to;
    if (!rst_n) begin
      m_en = 0; m_umin = 0; m_pulse = 0; m_hi = 0; m_fired = 0; m_sts = 0;
      m_pw = 0; m_range = 0; m_cnt = 0; m_ms = 0; m_sec = 0; m_pl = 0;
    end else begin
      st = m_en && !rwr && tick && (m_ms == TPS-1);
      mt = st && (m_sec == SPM-1);
      ut = m_umin ? mt : st;
      to = m_en && ut && !rwr && !m_fired && (m_cnt == 0);
      if (!m_en) m_pl = 0;
      else if (to && m_pulse) m_pl = width_of(m_pw);
      else if (tick && m_pl > 0) m_pl = m_pl - 1;
      if (rwr) begin m_cnt = wd; m_fired = 0; end
      else if (!m_en) begin m_cnt = m_range; m_fired = 0; end
      else if (ut && !m_fired) begin
        if (m_cnt == 0) m_fired = 1; else m_cnt = m_cnt - 1;
      end
      if (rwr) m_range = wd;
      if (!m_en || rwr) begin m_ms = 0; m_sec = 0; end
      else if (tick) begin
        if (m_ms == TPS-1) begin
          m_ms = 0;
          m_sec = (m_sec == SPM-1) ? 0 : m_sec + 1;
        end else m_ms = m_ms + 1;
      end
      if (to) m_sts = 1;
      else if (swr && wd[0]) m_sts = 0;
      if (cwr) begin
        m_en = wd[0]; m_umin = wd[1]; m_pulse = wd[2]; m_hi = wd[3]; m_pw = int'(wd[5:4]);
      end
    end
  end

  task automatic compare();
    bit act, e_alert;
    act = m_pulse ? (m_pl > 0) : (m_sts && m_en);
    e_alert = m_hi ? act : !act;
    vectors++;
    if (alert !== e_alert || oe !== act || sts !== m_sts) begin
      fails++;
      $display("FAIL %s cycle %0d: alert/oe/sts=%b%b%b expected %b%b%b",
               cur_req, cyc, alert, oe, sts, e_alert, act, m_sts);
    end
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      compare();
      tick = (tick_mode == 0) ? 1'b1 : ((cyc % 2) == 0);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] v);  cwr = 1; wd = v; step(1); cwr = 0; endtask
  task automatic wr_range(logic [7:0] v); rwr = 1; wd = v; step(1); rwr = 0; endtask
  task automatic wr_stat(logic [7:0] v);  swr = 1; wd = v; step(1); swr = 0; endtask

  task automatic restart_idle(logic [7:0] rng);
    wr_ctrl(8'h00); wr_stat(8'h01); wr_range(rng);
  endtask

  always @(posedge clk) begin
    total++;
    if (total > LIMIT && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", total);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(4);
    chk("R1", alert, 1'b1, "alert after reset");
    chk("R1", oe, 1'b0, "oe after reset");
    chk("R1", sts, 1'b0, "sts after reset");

    cur_req = "R2";
    wr_range(8'h00);
    step(40);
    chk("R2", sts, 1'b0, "no timeout while disabled");

    cur_req = "R3";
    wr_range(8'h03);
    wr_ctrl(8'h01);
    step(15);
    chk("R3", sts, 1'b0, "range 3 one cycle early");
    step(1);
    chk("R3", sts, 1'b1, "range 3 expiry");
    chk("R7", oe, 1'b1, "level alert asserted");
    chk("R9", alert, 1'b0, "active-low level");

    cur_req = "R6";
    wr_stat(8'h00);
    chk("R6", sts, 1'b1, "write 0 ignored");
    wr_stat(8'h01);
    chk("R6", sts, 1'b0, "write 1 clears");
    chk("R7", oe, 1'b0, "level released on clear");
    step(20);
    chk("R8", sts, 1'b0, "no refire without kick");

    cur_req = "R7";
    wr_range(8'h01);
    step(7);
    chk("R3", sts, 1'b0, "range 1 early");
    step(1);
    chk("R3", sts, 1'b1, "range 1 expiry");
    wr_ctrl(8'h00);
    chk("R7", oe, 1'b0, "disable releases alert");
    chk("R6", sts, 1'b1, "status survives disable");

    cur_req = "R5";
    wr_stat(8'h01);
    wr_range(8'h02);
    wr_ctrl(8'h01);
    for (int k = 0; k < 4; k++) begin
      step(6);
      wr_range(8'h02);
    end
    chk("R5", sts, 1'b0, "regular kicks hold off timeout");
    wr_range(8'h00);
    step(3);
    wr_range(8'h00);
    chk("R5", sts, 1'b0, "kick on expiry edge wins");
    step(3);
    chk("R5", sts, 1'b0, "prescaler restarted by kick");
    step(1);
    chk("R3", sts, 1'b1, "range 0 first unit event");

    cur_req = "R6";
    restart_idle(8'h00);
    wr_ctrl(8'h01);
    step(3);
    wr_stat(8'h01);
    chk("R6", sts, 1'b1, "set beats clear in same cycle");

    cur_req = "R4";
    restart_idle(8'h01);
    wr_ctrl(8'h03);
    step(23);
    chk("R4", sts, 1'b0, "minutes one cycle early");
    step(1);
    chk("R4", sts, 1'b1, "two minutes expiry");

    cur_req = "R8";
    for (int s = 0; s < 4; s++) begin
      restart_idle(8'h00);
      wr_ctrl(8'h05 | (s << 4));
      n = 0;
      for (int c = 0; c < 30; c++) begin
        step(1);
        if (oe) n++;
      end
      chk("R8", (n == width_of(s)), 1'b1, $sformatf("pulse width code %0d length %0d", s, n));
      chk("R8", sts, 1'b1, "pulse mode sets status");
    end

    cur_req = "R9";
    restart_idle(8'h00);
    wr_ctrl(8'h09);
    step(4);
    chk("R9", alert, 1'b1, "active-high asserted");
    chk("R9", oe, 1'b1, "driven while asserted");
    wr_stat(8'h01);
    chk("R9", alert, 1'b0, "active-high released level");
    chk("R9", oe, 1'b0, "released pin not driven");

    cur_req = "R3";
    tick_mode = 1;
    restart_idle(8'h02);
    wr_ctrl(8'h0D);
    step(60);
    chk("R3", sts, 1'b1, "sparse tick expiry");
    restart_idle(8'h01);
    wr_ctrl(8'h01);
    step(40);
    chk("R3", sts, 1'b1, "sparse tick level expiry");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule